// File: doc/BRIEF.md
# HDLC serial frame transmitter

This block turns a stream of parallel bytes into a serial HDLC bit stream for a line framer. It sends one output bit in each slot that the framer opens with a bit-enable strobe, and holds the output between slots. When no frame is waiting, the line carries flags back to back. A frame is an opening flag, the user bytes (address, control and information alike), a 16-bit frame check sequence and a closing flag. Zero-bit insertion applies to the user bits and to the check sequence. It never applies to the flags.

Bytes arrive on a valid/ready handshake, with a marker on the final byte of each frame. The block takes a byte only in the slot where the previous byte (or the opening flag) has sent its last bit. Inserted zeros therefore stretch the byte timing rather than needing a buffer. A closing flag can also serve as the opening flag of the next frame.

Top module: `hdlc_tx_serializer`

## Requirements
- R1: While `rst_n` is low, `tx_bit` is 1 and `in_ready` is 0.
- R2: `tx_bit` changes only on the clock edge that ends a cycle with `bit_en` high. From reset with no frame offered, each group of eight slots sends 0,1,1,1,1,1,1,0.
- R3: A frame goes out as a flag, then each accepted byte least significant bit first, then the check sequence, then a flag. A receiver that removes the inserted zeros recovers the offered bytes exactly.
- R4: The check sequence is a CRC with reflected polynomial 0x8408 (x^16+x^12+x^5+1) and preset 0xFFFF, run over the user bits in sent order. It is ones-complemented, low byte first, each byte least significant bit first. The CRC over the user bytes plus the two check bytes leaves the residue 0xF0B8.
- R5: After five consecutive 1s in the user or check bits, the next slot sends an inserted 0. A frame body never has six 1s in a row.
- R6: Flag bits are never stuffed. If the last check bit completes a run of five 1s, the inserted 0 comes before the closing flag.
- R7: The count of consecutive 1s restarts on every 0 sent, including an inserted 0, and is held at zero during flags. The number of inserted zeros per frame equals the number of disjoint runs of five 1s in the user and check bits.
- R8: `in_ready` is high only in a slot with `bit_en` high, at the last bit of a flag or of a non-final byte, and never in an inserted-zero slot. A byte is taken when `in_ready` and `in_valid` are both high, and `in_last` marks the final byte of a frame.
- R9: Frames offered back to back are separated by a single flag. That flag closes one frame and opens the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Framer strobe; one output bit per cycle in which it is high |
| in_data | input | 8 | Byte offered by the transmit FIFO |
| in_valid | input | 1 | `in_data` holds a byte. If low at a mid-frame byte boundary, the frame closes with its check sequence |
| in_last | input | 1 | The offered byte is the final one of its frame |
| in_ready | output | 1 | The offered byte is taken in this cycle if `in_valid` is high |
| tx_bit | output | 1 | Serial line bit |

## Verification
Zero-bit insertion can fall in the same slot as another event: a byte fetch, the start of the check sequence, or the start of the closing flag. In that slot the fetch or the flag must wait one slot. The bench provokes each case with bytes such as 0xF8 and runs of 0xFF, with a sweep of every single-byte frame, and with three strobe patterns (every cycle, every third cycle, pseudo-random). It judges each frame with its own destuffing receiver, compares bytes, check sequence and inserted-zero count with values computed arithmetically, and confirms that at least one frame needed a zero ahead of its closing flag. Assertions confirm that no byte is taken in an inserted-zero slot.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;

  localparam int CRC_W  = 16;
  localparam int FLAG_W = 8;
  localparam logic [FLAG_W-1:0] FLAG_PATTERN = 8'h7E;

  typedef logic [CRC_W-1:0] crc_t;

  typedef enum logic [1:0] {
    ST_FLAG = 2'd0,
    ST_DATA = 2'd1,
    ST_FCS  = 2'd2
  } tx_state_t;

  // One serial step of a reflected CRC register: feedback is the low bit
  // of the register against the incoming bit.
  function automatic crc_t crc_step(input crc_t cur, input logic din,
                                    input crc_t poly_r);
    logic fb;
    fb = cur[0] ^ din;
    return {1'b0, cur[CRC_W-1:1]} ^ (fb ? poly_r : '0);
  endfunction

  // Next value of the ones-run counter after one sent bit.
  function automatic int unsigned run_after(input int unsigned run,
                                            input logic sent,
                                            input logic counted);
    return (counted && sent) ? run + 1 : 0;
  endfunction

endpackage

// File: rtl/hdlc_fcs_gen.sv
module hdlc_fcs_gen
  import hdlc_tx_pkg::*;
#(
  parameter crc_t CRC_INIT   = 16'hFFFF,
  parameter crc_t CRC_POLY_R = 16'h8408
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic absorb,
  input  logic din,
  input  logic drain,
  output logic fcs_bit
);

  crc_t crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= CRC_INIT;
    end else if (clear) begin
      crc_q <= CRC_INIT;
    end else if (absorb) begin
      crc_q <= crc_step(crc_q, din, CRC_POLY_R);
    end else if (drain) begin
      crc_q <= {1'b1, crc_q[CRC_W-1:1]};
    end
  end

  // Complemented register, low bit first.
  assign fcs_bit = ~crc_q[0];

endmodule

// File: rtl/hdlc_zero_inserter.sv
module hdlc_zero_inserter
  import hdlc_tx_pkg::*;
#(
  parameter int STUFF_RUN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic slot,
  input  logic stuffable,
  input  logic sent_bit,
  output logic stuff_now
);

  localparam int RW = $clog2(STUFF_RUN + 1);

  logic [RW-1:0] run_q;

  assign stuff_now = stuffable && (run_q == RW'(STUFF_RUN));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
    end else if (slot) begin
      run_q <= RW'(run_after(int'(run_q), sent_bit, stuffable && !stuff_now));
    end
  end

endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
  import hdlc_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  input  logic              stuff_now,
  input  logic              fcs_bit,
  output logic              stuffable,
  output logic              next_bit,
  output logic              crc_clear,
  output logic              crc_absorb,
  output logic              crc_drain,
  output logic              body_emit,
  output logic              tx_bit
);

  localparam int CNT_MAX = (CRC_W > DATA_W) ? CRC_W : DATA_W;
  localparam int IW      = $clog2(CNT_MAX);

  tx_state_t         state_q;
  logic [IW-1:0]     idx_q;
  logic [DATA_W-1:0] shreg_q;
  logic              cur_last_q;
  logic              close_pend_q;
  logic              tx_q;

  logic at_flag_end, at_byte_end, at_fcs_end, flag_bit, tail_stuff;

  assign at_flag_end = (idx_q == IW'(FLAG_W - 1));
  assign at_byte_end = (idx_q == IW'(DATA_W - 1));
  assign at_fcs_end  = (idx_q == IW'(CRC_W - 1));
  assign flag_bit    = FLAG_PATTERN[3'(idx_q)];
  assign stuffable   = (state_q != ST_FLAG) || close_pend_q;
  assign tail_stuff  = close_pend_q && stuff_now;
  assign body_emit   = slot && stuffable;
  assign tx_bit      = tx_q;

  always_comb begin
    next_bit   = 1'b0;
    in_ready   = 1'b0;
    crc_clear  = 1'b0;
    crc_absorb = 1'b0;
    crc_drain  = 1'b0;
    unique case (state_q)
      ST_FLAG: begin
        if (!tail_stuff) begin
          next_bit = flag_bit;
          if (slot && at_flag_end) begin
            in_ready  = 1'b1;
            crc_clear = 1'b1;
          end
        end
      end
      ST_DATA: begin
        if (!stuff_now) begin
          next_bit   = shreg_q[0];
          crc_absorb = slot;
          in_ready   = slot && at_byte_end && !cur_last_q;
        end
      end
      ST_FCS: begin
        if (!stuff_now) begin
          next_bit  = fcs_bit;
          crc_drain = slot;
        end
      end
      default: next_bit = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_FLAG;
      idx_q        <= '0;
      shreg_q      <= '0;
      cur_last_q   <= 1'b0;
      close_pend_q <= 1'b0;
      tx_q         <= 1'b1;
    end else if (slot) begin
      tx_q <= next_bit;
      unique case (state_q)
        ST_FLAG: begin
          close_pend_q <= 1'b0;
          if (!tail_stuff) begin
            if (at_flag_end) begin
              idx_q <= '0;
              if (in_valid) begin
                shreg_q    <= in_data;
                cur_last_q <= in_last;
                state_q    <= ST_DATA;
              end
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_DATA: begin
          if (!stuff_now) begin
            shreg_q <= {1'b0, shreg_q[DATA_W-1:1]};
            if (at_byte_end) begin
              idx_q <= '0;
              if (!cur_last_q && in_valid) begin
                shreg_q    <= in_data;
                cur_last_q <= in_last;
              end else begin
                state_q <= ST_FCS;
              end
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_FCS: begin
          if (!stuff_now) begin
            if (at_fcs_end) begin
              idx_q        <= '0;
              state_q      <= ST_FLAG;
              close_pend_q <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_FLAG;
      endcase
    end
  end

endmodule

// File: rtl/hdlc_tx_serializer.sv
module hdlc_tx_serializer
  import hdlc_tx_pkg::*;
#(
  parameter int   DATA_W     = 8,
  parameter int   STUFF_RUN  = 5,
  parameter crc_t CRC_INIT   = 16'hFFFF,
  parameter crc_t CRC_POLY_R = 16'h8408
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  input  logic              in_last,
  output logic              in_ready,
  output logic              tx_bit
);

  // Named internal events, used by the bound checker.
  logic stuff_now;
  logic stuffable;
  logic next_bit;
  logic body_emit;
  logic crc_clear, crc_absorb, crc_drain, fcs_bit;

  hdlc_tx_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot       (bit_en),
    .in_data    (in_data),
    .in_valid   (in_valid),
    .in_last    (in_last),
    .in_ready   (in_ready),
    .stuff_now  (stuff_now),
    .fcs_bit    (fcs_bit),
    .stuffable  (stuffable),
    .next_bit   (next_bit),
    .crc_clear  (crc_clear),
    .crc_absorb (crc_absorb),
    .crc_drain  (crc_drain),
    .body_emit  (body_emit),
    .tx_bit     (tx_bit)
  );

  hdlc_zero_inserter #(.STUFF_RUN(STUFF_RUN)) u_stuff (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot      (bit_en),
    .stuffable (stuffable),
    .sent_bit  (next_bit),
    .stuff_now (stuff_now)
  );

  hdlc_fcs_gen #(.CRC_INIT(CRC_INIT), .CRC_POLY_R(CRC_POLY_R)) u_fcs (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (crc_clear),
    .absorb  (crc_absorb),
    .din     (next_bit),
    .drain   (crc_drain),
    .fcs_bit (fcs_bit)
  );

endmodule

// File: rtl/hdlc_tx_checker.sv
module hdlc_tx_checker #(
  parameter int STUFF_RUN = 5
) (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic in_ready,
  input logic tx_bit,
  input logic stuff_now,
  input logic body_emit,
  input logic next_bit
);

  localparam int RW = $clog2(STUFF_RUN + 2);
  localparam logic [RW-1:0] RUN_SAT = {RW{1'b1}};

  // Independent count of 1s sent in a row inside a frame body.
  logic [RW-1:0] body_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      body_run <= '0;
    end else if (bit_en) begin
      if (body_emit && next_bit) begin
        if (body_run != RUN_SAT) body_run <= body_run + 1'b1;
      end else begin
        body_run <= '0;
      end
    end
  end

  assert_run_limit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    body_run <= RW'(STUFF_RUN));

  assert_stuff_is_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en && stuff_now) |=> !tx_bit);

  assert_ready_in_slot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> bit_en);

  assert_no_fetch_on_stuff_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stuff_now |-> !in_ready);

  assert_hold_between_slots_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(tx_bit));

endmodule

bind hdlc_tx_serializer hdlc_tx_checker #(.STUFF_RUN(STUFF_RUN)) u_hdlc_tx_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_en    (bit_en),
  .in_ready  (in_ready),
  .tx_bit    (tx_bit),
  .stuff_now (stuff_now),
  .body_emit (body_emit),
  .next_bit  (next_bit)
);

// File: tb/test_hdlc_tx_serializer.sv
module test_hdlc_tx_serializer;

  localparam int MAXF = 300;
  localparam int MAXB = 1024;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic       tx_bit;

  always #10 clk = ~clk;  // 50 MHz

  hdlc_tx_serializer i_hdlc_tx_serializer (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_data(in_data),
    .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready), .tx_bit(tx_bit)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- frame table ----------------
  logic [7:0] fbytes [MAXB];
  int flen [MAXF];
  int foff [MAXF];
  int fgap [MAXF];
  int nframes = 0;
  int nbytes  = 0;
  int cur_frame = 0;

  task automatic open_frame(input int gap);
    foff[nframes] = nbytes;
    flen[nframes] = 0;
    fgap[nframes] = gap;
  endtask

  task automatic put(input logic [7:0] v);
    fbytes[nbytes] = v;
    nbytes++;
    flen[nframes]++;
  endtask

  task automatic close_frame();
    nframes++;
  endtask

  task automatic build();
    open_frame(20); put(8'hF8); close_frame();
    open_frame(20); put(8'hFF); put(8'hFF); close_frame();
    open_frame(7);  put(8'h7E); put(8'h7E); put(8'h7E); close_frame();
    open_frame(0);  put(8'hF8); put(8'h1F); put(8'hF8); close_frame();
    open_frame(13);
    for (int i = 0; i < 16; i++) put(8'(i * 17));
    close_frame();
    open_frame(0);  put(8'h00); close_frame();
    open_frame(3);
    for (int i = 0; i < 6; i++) put(8'hFF);
    close_frame();
    for (int v = 0; v < 256; v++) begin
      open_frame((v % 16 == 0) ? 5 : 0);
      put(8'(v));
      close_frame();
    end
  endtask

  // ---------------- bench arithmetic ----------------
  function automatic logic [15:0] bench_crc(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if ((r[0] ^ d[i]) == 1'b1) r = (r >> 1) ^ 16'h8408;
      else r = r >> 1;
    end
    return r;
  endfunction

  function automatic logic [15:0] frame_fcs(input int k);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int j = 0; j < flen[k]; j++) c = bench_crc(c, fbytes[foff[k] + j]);
    return ~c;
  endfunction

  // Disjoint runs of five 1s over user bits then check bits.
  function automatic int exp_stuffs(input int k, input logic [15:0] fcs, output bit tail);
    int run, n, nb;
    logic [7:0] v;
    run = 0; n = 0; tail = 1'b0; nb = flen[k] + 2;
    for (int j = 0; j < nb; j++) begin
      if (j < flen[k]) v = fbytes[foff[k] + j];
      else if (j == flen[k]) v = fcs[7:0];
      else v = fcs[15:8];
      for (int i = 0; i < 8; i++) begin
        tail = 1'b0;
        if (v[i]) begin
          run++;
          if (run == 5) begin n++; run = 0; tail = 1'b1; end
        end else begin
          run = 0;
        end
      end
    end
    return n;
  endfunction

  // ---------------- receiver model ----------------
  logic [7:0] sr = 8'h00;
  bit   synced = 1'b0;
  int   ones = 0;
  int   rlen = 0;
  int   rstuff = 0;
  bit   rbits [512];
  int   frames_done = 0;
  int   flags_between = 0;
  int   shared_flags = 0;
  int   tail_frames = 0;

  task automatic finish_frame();
    int k, nb;
    logic [7:0] v;
    logic [15:0] fcs, rx_fcs, res;
    bit data_ok, tail;
    int exp_n;
    k = frames_done;
    if (k >= nframes) begin
      check(1'b0, "R3", "unexpected extra frame", k, nframes);
    end else begin
      nb = flen[k];
      check(rlen == (nb + 2) * 8, "R3", "frame bit length", rlen, (nb + 2) * 8);
      if (rlen == (nb + 2) * 8) begin
        data_ok = 1'b1;
        res = 16'hFFFF;
        rx_fcs = 16'h0000;
        for (int j = 0; j < nb + 2; j++) begin
          for (int i = 0; i < 8; i++) v[i] = rbits[j * 8 + i];
          res = bench_crc(res, v);
          if (j < nb) begin
            if (v != fbytes[foff[k] + j]) data_ok = 1'b0;
          end else if (j == nb) rx_fcs[7:0] = v;
          else rx_fcs[15:8] = v;
        end
        check(data_ok, "R3", "user bytes of frame", k, k);
        fcs = frame_fcs(k);
        check(rx_fcs == fcs, "R4", "check sequence", int'(rx_fcs), int'(fcs));
        check(res == 16'hF0B8, "R4", "receiver residue", int'(res), 32'hF0B8);
        exp_n = exp_stuffs(k, fcs, tail);
        check(rstuff == exp_n, "R5 R7", "inserted zero count", rstuff, exp_n);
        if (tail) tail_frames++;
      end
      if (flags_between == 1 && k > 0) shared_flags++;
    end
    frames_done++;
  endtask

  task automatic rx_bit(input logic b);
    sr = {sr[6:0], b};
    if (sr == 8'h7E) begin
      if (synced) begin
        rlen = (rlen >= 6) ? rlen - 6 : 0;
        if (rlen > 0) begin
          finish_frame();
          flags_between = 1;
        end else begin
          flags_between++;
        end
      end
      synced = 1'b1;
      rlen = 0;
      rstuff = 0;
      ones = 0;
    end else if (synced) begin
      if (b) begin
        if (ones == 5) ones = 6;
        else if (ones >= 6) begin
          check(1'b0, "R5", "six ones inside frame", ones + 1, 5);
          ones = 0;
        end else begin
          if (rlen < 512) rbits[rlen] = 1'b1;
          rlen++;
          ones++;
        end
      end else begin
        if (ones == 5) rstuff++;
        else begin
          if (rlen < 512) rbits[rlen] = 1'b0;
          rlen++;
        end
        ones = 0;
      end
    end
  endtask

  // ---------------- strobe generator ----------------
  logic [15:0] lfsr = 16'hACE1;
  int div3 = 0;
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    div3 = (div3 + 1) % 3;
    case (cur_frame % 3)
      0: bit_en = 1'b1;
      1: bit_en = (div3 == 0);
      default: bit_en = lfsr[0];
    endcase
  end

  // ---------------- output monitor ----------------
  int   slot_cnt = 0;
  logic idle_bits [24];
  logic last_tx = 1'b1;
  logic slot_s;
  always @(posedge clk) begin
    slot_s = bit_en & rst_n;
    #2;
    if (slot_s) begin
      if (slot_cnt < 24) idle_bits[slot_cnt] = tx_bit;
      slot_cnt++;
      rx_bit(tx_bit);
    end else if (rst_n) begin
      check(tx_bit == last_tx, "R2", "output moved without strobe", int'(tx_bit), int'(last_tx));
    end
    last_tx = tx_bit;
  end

  // ---------------- driver ----------------
  int accepted = 0;

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    build();
    repeat (5) @(negedge clk);
    #1;
    check(tx_bit == 1'b1, "R1", "tx_bit in reset", int'(tx_bit), 1);
    check(in_ready == 1'b0, "R1", "in_ready in reset", int'(in_ready), 0);
    @(negedge clk);
    rst_n = 1'b1;
    wait (slot_cnt >= 24);
    for (int i = 0; i < 24; i++) begin
      logic e;
      e = ((i % 8) == 0 || (i % 8) == 7) ? 1'b0 : 1'b1;
      check(idle_bits[i] == e, "R2", "idle flag bit", int'(idle_bits[i]), int'(e));
    end
    for (int f = 0; f < nframes; f++) begin
      cur_frame = f;
      repeat (fgap[f]) @(negedge clk);
      for (int b = 0; b < flen[f]; b++) begin
        in_data  = fbytes[foff[f] + b];
        in_last  = (b == flen[f] - 1);
        in_valid = 1'b1;
        forever begin
          @(negedge clk);
          #1;
          if (in_ready) break;
        end
        check(bit_en == 1'b1, "R8", "byte taken outside a strobe slot", int'(bit_en), 1);
        accepted++;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_last  = 1'b0;
      end
    end
    wait (frames_done >= nframes);
    repeat (10) @(negedge clk);
    check(accepted == nbytes, "R8", "bytes accepted", accepted, nbytes);
    check(frames_done == nframes, "R6 R9", "frames closed by flags", frames_done, nframes);
    check(tail_frames > 0, "R6", "frames with zero before closing flag", tail_frames, 1);
    check(shared_flags > 0, "R9", "frames sharing one flag", shared_flags, 1);
    finish_run();
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "R3", "watchdog expired", frames_done, nframes);
    finish_run();
  end

endmodule